// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Controller

This block keeps the processor's global interrupt enable bit and its halt state. The instruction decoder tells it, once per completed instruction, whether that instruction was a disable, an enable, a return-from-interrupt or a halt. From the same strobes the block decides when the enable bit changes and when the core may sleep. It also decides when an interrupt request goes to the dispatch logic, and when the next opcode fetch must leave the program counter where it is.

The enable instruction takes effect only after the instruction that follows it has completed. Return-from-interrupt takes effect at once. A halt issued with the enable bit clear and an interrupt already pending does not sleep. Instead it raises a one-shot flag that makes the fetch unit read the next opcode byte twice. Picking the vector, pushing the stack and storing the enable and flag registers are handled elsewhere.

Top module: `irq_gate`

## Requirements
- R1: After reset `ime`, `halted` and `pc_hold` are 0, and no delayed enable is waiting.
- R2: A completed disable instruction (`insn_done` and `op_di`) clears `ime` on the next cycle. It also drops a delayed enable that has not yet landed.
- R3: A completed enable instruction does not change `ime`. `ime` becomes 1 on the cycle after the next completed instruction.
- R4: A completed return-from-interrupt sets `ime` on the next cycle.
- R5: An interrupt is pending only when `ie_mask & if_flags` is nonzero. Bits set in only one of the two vectors never count.
- R6: `dispatch_req` is high when `ime` is 1, an interrupt is pending, and either `insn_done` is high or the core is halted. On the next cycle `ime` is 0, `halted` is 0, and any delayed enable is dropped.
- R7: A disable that completes in the delay slot of an enable leaves `ime` at 0.
- R8: A halt completed while `ime` is 1 sets `halted`. `halted` stays set until an interrupt becomes pending, and that interrupt is then dispatched.
- R9: A halt completed while `ime` is 0 with nothing pending sets `halted`. When an interrupt becomes pending, `wake` is high for one cycle with `dispatch_req` low, and `halted` clears.
- R10: A halt completed while `ime` is 0 with an interrupt pending leaves `halted` at 0. It sets `pc_hold`, which stays high until the next completed instruction.
- R11: While halted, `insn_done` and the op strobes are ignored. The op strobes are also ignored whenever `insn_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | An instruction completes this cycle |
| op_di | input | 1 | The completing instruction is a disable |
| op_ei | input | 1 | The completing instruction is an enable |
| op_reti | input | 1 | The completing instruction is a return-from-interrupt |
| op_halt | input | 1 | The completing instruction is a halt |
| ie_mask | input | IRQ_W | Interrupt enable register value |
| if_flags | input | IRQ_W | Interrupt flag register value |
| ime | output | 1 | Interrupt master enable |
| halted | output | 1 | Core is halted |
| dispatch_req | output | 1 | Dispatch an interrupt now |
| wake | output | 1 | A pending interrupt ends the halt |
| pc_hold | output | 1 | Do not increment the PC on the next opcode fetch |

## Verification
The enable instruction is followed by an ordinary instruction, by a disable and by a dispatch. These three cases separate the delayed enable from the immediate one, and show both ways a delayed enable is cancelled. Halt is issued in all three entry states: enable set, enable clear with nothing pending, and enable clear with something pending. This shows that the sleep, wake-without-dispatch and double-fetch paths stay distinct. Flag and enable vectors that do not overlap confirm that only their AND counts as pending. Boundary strobes sent while halted confirm that they are ignored.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             op_di,
  input  logic             op_ei,
  input  logic             op_reti,
  input  logic             op_halt,
  input  logic [IRQ_W-1:0] ie_mask,
  input  logic [IRQ_W-1:0] if_flags,
  output logic             ime,
  output logic             halted,
  output logic             dispatch_req,
  output logic             wake,
  output logic             pc_hold
);

  logic ime_q, ei_pend_q, halted_q, skip_q;
  logic pending, boundary;

  assign pending      = |(ie_mask & if_flags);
  assign boundary     = insn_done & ~halted_q;
  assign dispatch_req = ime_q & pending & (insn_done | halted_q);
  assign wake         = halted_q & pending;
  assign ime          = ime_q;
  assign halted       = halted_q;
  assign pc_hold      = skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime_q     <= 1'b0;
      ei_pend_q <= 1'b0;
      halted_q  <= 1'b0;
      skip_q    <= 1'b0;
    end else if (dispatch_req) begin
      ime_q     <= 1'b0;
      ei_pend_q <= 1'b0;
      halted_q  <= 1'b0;
      skip_q    <= 1'b0;
    end else if (halted_q) begin
      if (pending) halted_q <= 1'b0;
    end else if (insn_done) begin
      if (op_di)                      ime_q <= 1'b0;
      else if (op_reti || ei_pend_q)  ime_q <= 1'b1;
      ei_pend_q <= op_ei & ~op_di;
      halted_q  <= op_halt & ~(~ime_q & pending);
      skip_q    <= op_halt & ~ime_q & pending;
    end
  end

  assert_di_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && op_di) |=> !ime_q);

  assert_reti_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && op_reti && !op_di && !dispatch_req) |=> ime_q);

  assert_ime_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ime_q) |-> $past(boundary && (op_reti || ei_pend_q)));

  assert_dispatch_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_req |=> (!ime_q && !halted_q));

  assert_wake_exits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !halted_q);

  assert_hold_not_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted_q && skip_q));

endmodule

// File: tb/irq_gate_test.sv
module irq_gate_test;
  localparam int W = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 0, di = 0, ei = 0, reti = 0, hlt = 0;
  logic [W-1:0] ie = '0, fl = '0;
  logic ime, halted, dispatch_req, wake, pc_hold;
  int tests = 0, fails = 0, cyc = 0;
  bit m_ime = 0, m_ep = 0, m_hlt = 0, m_skp = 0;

  always #4 clk = ~clk;

  irq_gate #(.IRQ_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .insn_done(done), .op_di(di), .op_ei(ei),
    .op_reti(reti), .op_halt(hlt), .ie_mask(ie), .if_flags(fl),
    .ime(ime), .halted(halted), .dispatch_req(dispatch_req), .wake(wake),
    .pc_hold(pc_hold));

  task automatic cmp(string tag, string nm, bit act, bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", tag, nm, act, exp, cyc);
    end
  endtask

  task automatic step(string tag, bit d, bit o_di, bit o_ei, bit o_rt, bit o_h,
                      logic [W-1:0] e, logic [W-1:0] f);
    bit pend, disp;
    @(negedge clk);
    done = d; di = o_di; ei = o_ei; reti = o_rt; hlt = o_h; ie = e; fl = f;
    #1;
    pend = (e & f) != 0;
    disp = m_ime && pend && (d || m_hlt);
    cmp(tag, "ime", ime, m_ime);
    cmp(tag, "halted", halted, m_hlt);
    cmp(tag, "dispatch_req", dispatch_req, disp);
    cmp(tag, "wake", wake, m_hlt && pend);
    cmp(tag, "pc_hold", pc_hold, m_skp);
    if (disp) begin
      m_ime = 0; m_ep = 0; m_hlt = 0; m_skp = 0;
    end else if (m_hlt) begin
      if (pend) m_hlt = 0;
    end else if (d) begin
      bit was = m_ime;
      if (o_di) m_ime = 0;
      else if (o_rt || m_ep) m_ime = 1;
      m_ep  = o_ei && !o_di;
      m_hlt = o_h && !(!was && pend);
      m_skp = o_h && !was && pend;
    end
    @(posedge clk);
    cyc++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step("R1", 0, 1, 1, 1, 1, 5'h1F, 5'h00);
    step("R1", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R3: delayed enable, then ordinary instruction, then active
    step("R3", 1, 0, 1, 0, 0, 5'h00, 5'h00);
    step("R3", 1, 0, 0, 0, 0, 5'h00, 5'h00);
    step("R3", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R5: disjoint bits are not pending
    step("R5", 1, 0, 0, 0, 0, 5'h01, 5'h02);
    step("R5", 1, 0, 0, 0, 0, 5'h18, 5'h07);
    // R6: dispatch at boundary
    step("R6", 0, 0, 0, 0, 0, 5'h04, 5'h04);
    step("R6", 1, 0, 0, 0, 0, 5'h04, 5'h04);
    step("R6", 1, 0, 0, 0, 0, 5'h04, 5'h04);
    // R4: return-from-interrupt immediate
    step("R4", 1, 0, 0, 1, 0, 5'h00, 5'h00);
    step("R4", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R2: disable
    step("R2", 1, 1, 0, 0, 0, 5'h00, 5'h00);
    step("R2", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R7: disable in delay slot
    step("R7", 1, 0, 1, 0, 0, 5'h00, 5'h00);
    step("R7", 1, 1, 0, 0, 0, 5'h00, 5'h00);
    step("R7", 1, 0, 0, 0, 0, 5'h00, 5'h00);
    step("R7", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R6: dispatch cancels a delayed enable
    step("R6", 1, 0, 0, 1, 0, 5'h00, 5'h00);
    step("R6", 1, 0, 1, 0, 0, 5'h02, 5'h02);
    step("R6", 1, 0, 0, 0, 0, 5'h00, 5'h00);
    step("R6", 1, 0, 0, 0, 0, 5'h00, 5'h00);
    // R8 and R11: halt with enable set
    step("R8", 1, 0, 0, 1, 0, 5'h00, 5'h00);
    step("R8", 1, 0, 0, 0, 1, 5'h00, 5'h00);
    step("R11", 1, 1, 0, 0, 0, 5'h00, 5'h00);
    step("R11", 1, 0, 0, 0, 1, 5'h0F, 5'h10);
    step("R8", 0, 0, 0, 0, 0, 5'h08, 5'h08);
    step("R8", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R9: halt with enable clear, nothing pending
    step("R9", 1, 0, 0, 0, 1, 5'h00, 5'h00);
    step("R9", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    step("R9", 0, 0, 0, 0, 0, 5'h10, 5'h10);
    step("R9", 0, 0, 0, 0, 0, 5'h10, 5'h10);
    // R10: halt with enable clear and interrupt pending
    step("R10", 1, 0, 0, 0, 1, 5'h01, 5'h01);
    step("R10", 0, 0, 0, 0, 0, 5'h01, 5'h01);
    step("R10", 1, 0, 0, 0, 0, 5'h01, 5'h01);
    step("R10", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    // R11: strobes without insn_done
    step("R11", 0, 0, 1, 1, 1, 5'h00, 5'h00);
    step("R11", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    step("R11", 1, 0, 0, 0, 0, 5'h00, 5'h00);
    step("R11", 0, 0, 0, 0, 0, 5'h00, 5'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule